// File: doc/BRIEF.md
# Status-Bit Completion Poller for Flash Program and Erase

This controller sits on the host side of a parallel flash interface. It decides when an internal program or erase operation in the flash has finished. The host first writes the command sequence on its own. It then starts the poller with the kind of operation, the address to poll and the data bit that was written into the status position. When the host also signals that the final command write has gone out, the poller begins issuing reads over a simple request/acknowledge memory port. It compares the status bit of every returned word with the value that marks completion.

The status bit can show its final value before the rest of the word is valid. For that reason, a single matching read never ends the operation. The poller always issues one more read. It reports completion only when that extra read matches as well, and it returns the word from that extra read as the final data. Each operation gets a budget of poll reads. If the budget runs out, the poller reports a timeout instead of completion.

Top module: `poll_done_ctrl`

## Requirements
- R1: After reset the poller is idle: `busy_o`, `mem_req_o`, `done_o` and `timeout_o` are 0 and `word_o` is all zeros.
- R2: While idle, a high `start_i` is accepted on the next clock edge. The poller latches `addr_i`. The completion value is `exp_bit_i` when `op_erase_i` is 0 (program) and the constant 1 when `op_erase_i` is 1 (erase).
- R3: After a start is accepted, no read request is raised until `seq_done_i` has been sampled high.
- R4: Every read uses the latched address. `mem_req_o` stays high with a stable `mem_addr_o` until `mem_ack_i` completes the read. An acknowledged read delivers `mem_rdata_i` in the same cycle.
- R5: Bit 7 of `mem_rdata_i` (parameter `STAT_BIT`) is the status bit. When a poll read matches the completion value, one confirming read follows. `done_o` is raised only if the confirming read also matches, and `word_o` then holds the data word of the confirming read.
- R6: A confirming read that does not match sends the poller back to poll reads, as long as budget remains.
- R7: `limit_i`, sampled at start, is the number of poll reads allowed. A value of 0 counts as 1. Confirming reads are not charged to the budget. When a poll read misses and the budget is then used up, `timeout_o` pulses and the poller returns to idle.
- R8: A match on the last budgeted poll read still leads to a confirming read. If that confirming read fails, the result is a timeout.
- R9: `done_o` and `timeout_o` are single-cycle pulses and never high together. `word_o` keeps its value until the next accepted start, which clears it to zero.
- R10: `start_i` while busy is ignored. The running operation keeps its address and completes as if no start had been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a polling run (accepted when idle) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| exp_bit_i | input | 1 | Data bit that was programmed into the status position |
| addr_i | input | AW | Address to poll |
| limit_i | input | CW | Poll read budget |
| seq_done_i | input | 1 | The final command write has been issued |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | AW | Read address |
| mem_ack_i | input | 1 | Read completed; data valid this cycle |
| mem_rdata_i | input | DW | Read data |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Budget exhausted pulse |
| word_o | output | DW | Word captured by the confirming read |

## Verification
Exhausting the budget and detecting a match can both happen on the same poll read. This occurs when the last budgeted read is the first one to show the completion value. The bench forces this case with directed status sequences, in which the final allowed poll read matches and is followed by a confirming read that either matches or misses. A correct design starts the confirming read in both variants. It then ends in done or in timeout, and the bench judges the outcome, the captured word and the exact number of reads against its own requirement-level model. Random status streams with a mixed match probability also reach this collision by chance.

// File: rtl/poll_pkg.sv
package poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_POLL = 2'd2,
        ST_CONF = 2'd3
    } poll_state_e;
endpackage

// File: rtl/poll_target.sv
// Holds the poll address and the completion value for the running operation
module poll_target #(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          erase_i,
    input  logic          exp_bit_i,
    input  logic [AW-1:0] addr_i,
    input  logic          stat_bit_i,
    output logic [AW-1:0] addr_o,
    output logic          hit_o
);
    logic [AW-1:0] addr_d, addr_q;
    logic          want_d, want_q;

    always_comb begin
        addr_d = addr_q;
        want_d = want_q;
        if (load_i) begin
            addr_d = addr_i;
            // erase completes on a 1, program on the true data bit
            want_d = erase_i ? 1'b1 : exp_bit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            want_q <= 1'b0;
        end else begin
            addr_q <= addr_d;
            want_q <= want_d;
        end
    end

    assign addr_o = addr_q;
    assign hit_o  = (stat_bit_i == want_q);

    p_target_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(addr_o));
endmodule

// File: rtl/poll_budget.sv
// Counts the poll reads left in the current run
module poll_budget #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] limit_i,
    input  logic          dec_i,
    output logic          last_o,
    output logic          zero_o
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (limit_i == '0) ? ONE : limit_i;
        end else if (dec_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last_o = (cnt_q == ONE);
    assign zero_o = (cnt_q == '0);

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dec_i |-> !zero_o);
    p_load_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !zero_o);
endmodule

// File: rtl/poll_done_ctrl.sv
module poll_done_ctrl
    import poll_pkg::*;
#(
    parameter int AW       = 24,
    parameter int DW       = 16,
    parameter int CW       = 16,
    parameter int STAT_BIT = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          op_erase_i,
    input  logic          exp_bit_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] limit_i,
    input  logic          seq_done_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic          mem_ack_i,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          timeout_o,
    output logic [DW-1:0] word_o
);
    typedef struct packed {
        poll_state_e   st;
        logic          done;
        logic          tout;
        logic [DW-1:0] word;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic load, dec, hit, last, zero;

    poll_target #(.AW(AW)) u_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .erase_i   (op_erase_i),
        .exp_bit_i (exp_bit_i),
        .addr_i    (addr_i),
        .stat_bit_i(mem_rdata_i[STAT_BIT]),
        .addr_o    (mem_addr_o),
        .hit_o     (hit)
    );

    poll_budget #(.CW(CW)) u_budget (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .limit_i(limit_i),
        .dec_i  (dec),
        .last_o (last),
        .zero_o (zero)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.tout = 1'b0;
        load       = 1'b0;
        dec        = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    load       = 1'b1;
                    ctl_d.word = '0;
                    ctl_d.st   = ST_ARM;
                end
            end
            ST_ARM: begin
                if (seq_done_i) ctl_d.st = ST_POLL;
            end
            ST_POLL: begin
                if (mem_ack_i) begin
                    dec = 1'b1;
                    if (hit) begin
                        ctl_d.st = ST_CONF;
                    end else if (last) begin
                        ctl_d.tout = 1'b1;
                        ctl_d.st   = ST_IDLE;
                    end
                end
            end
            ST_CONF: begin
                if (mem_ack_i) begin
                    if (hit) begin
                        ctl_d.done = 1'b1;
                        ctl_d.word = mem_rdata_i;
                        ctl_d.st   = ST_IDLE;
                    end else if (zero) begin
                        ctl_d.tout = 1'b1;
                        ctl_d.st   = ST_IDLE;
                    end else begin
                        ctl_d.st = ST_POLL;
                    end
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st   <= ST_IDLE;
            ctl_q.done <= 1'b0;
            ctl_q.tout <= 1'b0;
            ctl_q.word <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign mem_req_o = (ctl_q.st == ST_POLL) || (ctl_q.st == ST_CONF);
    assign busy_o    = (ctl_q.st != ST_IDLE);
    assign done_o    = ctl_q.done;
    assign timeout_o = ctl_q.tout;
    assign word_o    = ctl_q.word;

    p_seq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_ARM && !seq_done_i) |=> !mem_req_o);
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));
    p_done_after_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(mem_ack_i && hit));
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_tout_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);
    p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_i && !busy_o) |=> (done_o || $stable(word_o)));
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !mem_ack_i) |=> busy_o);
endmodule

// File: tb/test_poll_done_ctrl.sv
module test_poll_done_ctrl;
    localparam int  AW = 24;
    localparam int  DW = 16;
    localparam int  CW = 16;
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, op_erase_i = 1'b0, exp_bit_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] limit_i = '0;
    logic          seq_done_i = 1'b0;
    logic          mem_req_o, mem_ack_i = 1'b0;
    logic [AW-1:0] mem_addr_o;
    logic [DW-1:0] mem_rdata_i = '0;
    logic          busy_o, done_o, timeout_o;
    logic [DW-1:0] word_o;

    int checks = 0, errors = 0;
    logic [DW-1:0] resp [64];
    int            rd_idx = 0;
    int            addr_bad = 0;
    logic [AW-1:0] cur_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    poll_done_ctrl #(.AW(AW), .DW(DW), .CW(CW)) i_poll_done_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
        .exp_bit_i(exp_bit_i), .addr_i(addr_i), .limit_i(limit_i),
        .seq_done_i(seq_done_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .busy_o(busy_o),
        .done_o(done_o), .timeout_o(timeout_o), .word_o(word_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model: acknowledges requests after a random wait
    initial begin
        forever begin
            @(negedge clk);
            mem_ack_i = 1'b0;
            if (mem_req_o && ($urandom % 2 == 0)) begin
                mem_ack_i   = 1'b1;
                mem_rdata_i = resp[rd_idx];
                if (mem_addr_o != cur_addr) addr_bad++;
                if (rd_idx < 63) rd_idx++;
            end
        end
    end

    // requirement-level model: outcome 1 = done, 2 = timeout
    task automatic predict(input bit want, input int limit,
                           output int kind, output logic [DW-1:0] w, output int reads);
        int  rem = (limit == 0) ? 1 : limit;
        bit  conf = 1'b0;
        reads = 0; kind = 0; w = '0;
        while (kind == 0) begin
            logic [DW-1:0] r = resp[reads];
            reads++;
            if (!conf) begin
                rem--;
                if (r[7] == want) conf = 1'b1;
                else if (rem == 0) kind = 2;
            end else begin
                if (r[7] == want) begin kind = 1; w = r; end
                else if (rem == 0) kind = 2;
                else conf = 1'b0;
            end
        end
    endtask

    function automatic bit want_of(input bit erase, input bit eb);
        return erase ? 1'b1 : eb;
    endfunction

    task automatic fill_random(input bit want, input int pct);
        for (int i = 0; i < 64; i++) begin
            logic [DW-1:0] r = DW'($urandom);
            r[7] = ($urandom % 100 < pct) ? want : ~want;
            resp[i] = r;
        end
    endtask

    task automatic set_bits(input bit want, input string pat);
        // pat: 'm' = matching status bit, 'x' = non-matching
        for (int i = 0; i < 64; i++) begin
            logic [DW-1:0] r = DW'($urandom);
            r[7] = (i < pat.len() && pat[i] == "m") ? want : ~want;
            resp[i] = r;
        end
    endtask

    task automatic run_op(input string tag, input bit erase, input bit eb,
                          input logic [AW-1:0] a, input int limit,
                          input int arm_wait, input bit inject);
        int kind, reads, k;
        logic [DW-1:0] w;
        bit req_early = 1'b0;
        predict(want_of(erase, eb), limit, kind, w, reads);
        rd_idx = 0; addr_bad = 0; cur_addr = a;
        @(negedge clk);
        start_i = 1'b1; op_erase_i = erase; exp_bit_i = eb;
        addr_i = a; limit_i = CW'(limit);
        @(negedge clk);
        start_i = 1'b0; addr_i = ~a; op_erase_i = ~erase; limit_i = '1;
        chk(word_o == '0, "R9", {tag, " word cleared at start"}, 32'(word_o), 0);
        for (int i = 0; i < arm_wait; i++) begin
            if (mem_req_o) req_early = 1'b1;
            @(negedge clk);
        end
        chk(!req_early && !mem_req_o, "R3", {tag, " no request before seq_done"},
            32'(req_early), 0);
        seq_done_i = 1'b1;
        @(negedge clk);
        seq_done_i = 1'b0;
        if (inject) begin
            start_i = 1'b1; addr_i = a ^ 24'h5a5a5a;
            @(negedge clk);
            start_i = 1'b0;
        end
        k = 0;
        while (!done_o && !timeout_o && k < 2000) begin
            @(negedge clk);
            k++;
        end
        chk(32'(done_o) == 32'(kind == 1) && 32'(timeout_o) == 32'(kind == 2),
            "R7", {tag, " outcome done/timeout"}, {30'd0, timeout_o, done_o},
            (kind == 1) ? 1 : 2);
        chk(rd_idx == reads, "R5", {tag, " number of reads"}, 32'(rd_idx), 32'(reads));
        chk(addr_bad == 0, "R4", {tag, " read address"}, 32'(addr_bad), 0);
        if (kind == 1)
            chk(word_o == w, "R5", {tag, " captured word"}, 32'(word_o), 32'(w));
        w = word_o;
        @(negedge clk);
        chk(!done_o && !timeout_o && !busy_o && word_o == w, "R9",
            {tag, " pulse ends and word held"}, {done_o, timeout_o, busy_o, 13'd0, word_o}, 32'(w));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy_o && !mem_req_o && !done_o && !timeout_o && word_o == '0, "R1",
            "state during reset", {busy_o, mem_req_o, done_o, timeout_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !mem_req_o && word_o == '0, "R1", "idle after reset",
            {busy_o, mem_req_o, 14'd0, word_o}, 0);

        // R7: zero budget acts as one poll read
        set_bits(1'b1, "x");
        run_op("R7_zero_limit", 1'b0, 1'b1, 24'h000100, 0, 2, 1'b0);
        // R5: plain completion with confirmation
        set_bits(1'b0, "xxmm");
        run_op("R5_basic", 1'b0, 1'b0, 24'h123456, 3, 1, 1'b0);
        // R8: match on last budgeted read, confirm fails -> timeout
        set_bits(1'b1, "xmx");
        run_op("R8_last_fail", 1'b0, 1'b1, 24'h00abcd, 2, 0, 1'b0);
        // R8: match on last budgeted read, confirm passes -> done
        set_bits(1'b1, "xmm");
        run_op("R8_last_ok", 1'b0, 1'b1, 24'h00abce, 2, 3, 1'b0);
        // R6: confirm miss goes back to polling
        set_bits(1'b0, "mxxmm");
        run_op("R6_reconfirm", 1'b0, 1'b0, 24'h777000, 4, 1, 1'b0);
        // R2: erase ignores exp_bit_i and completes on 1
        set_bits(1'b1, "xxmm");
        run_op("R2_erase", 1'b1, 1'b0, 24'h400000, 5, 2, 1'b0);
        // R10: start while busy is ignored
        set_bits(1'b0, "xxxxmm");
        run_op("R10_busy_start", 1'b0, 1'b0, 24'h0f0f0f, 8, 1, 1'b1);

        for (int n = 0; n < 30; n++) begin
            bit er = 1'($urandom);
            bit eb = 1'($urandom);
            fill_random(want_of(er, eb), 35 + int'($urandom % 40));
            run_op("rand", er, eb, AW'($urandom), int'($urandom % 7),
                   int'($urandom % 4), 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule